// File: doc/BRIEF.md
# Five-Step Multicycle RISC Core

This block is a small 32-bit processor that runs one instruction at a time. No instructions overlap. Each instruction steps through fetch, decode with register read, execute or address forming, data memory access and write-back, and each step takes one clock. An instruction skips the steps it does not need. The core talks to an instruction memory and a data memory. Both memories are word addressed and have combinational read. The core stops on a halt instruction and raises `halted`.

Branches resolve early. During decode the core reads the register file, sign-extends the 16-bit offset, compares the two operands for equality and adds the branch target, all in the same step. A branch therefore finishes in two cycles. Loads are the only instructions that use all five steps.

Instruction fields: opcode in bits 31..26, first source register in 25..21, second source or immediate destination in 20..16, register-register destination in 15..11, 16-bit immediate in 15..0, and register-register function in 2..0.

Top module: `mc5_core`

## Requirements
- R1: While `rst` is high and on its release, the program counter is 0 and `imem_addr` is 0. `halted`, `dmem_re` and `dmem_we` are low, and execution starts with a fetch.
- R2: `imem_addr` is the byte program counter divided by 4. Each fetch advances the counter by 4, so a straight-line program fetches consecutive words.
- R3: Opcode 0x00 is register-register. Function 0 is add, 1 subtract (rs-rt), 2 AND, 3 OR, 4 XOR and 5 signed set-less-than (1 or 0). Any other function value acts as add. The result goes to the register in bits 15..11.
- R4: Opcodes 0x08 add, 0x0A signed set-less-than, 0x0C AND, 0x0D OR and 0x0E XOR combine the first source with the sign-extended immediate. The result goes to the register in bits 20..16.
- R5: Opcode 0x23 (load) and opcode 0x2B (store) use the byte address base + sign-extended offset. `dmem_addr` carries that address divided by 4. A store drives the second source register on `dmem_wdata` with `dmem_we`. A load samples `dmem_rdata` with `dmem_re` and writes the register in bits 20..16.
- R6: Opcode 0x04 branches when both source registers are equal. The target is (address of the branch + 4) + (sign-extended offset × 4). Taken and not-taken branches both take 2 cycles.
- R7: Register ALU ops and stores take 4 cycles, and loads take 5 cycles.
- R8: Register 0 always reads as zero. Writes to it, from an ALU op or a load, have no effect.
- R9: Opcode 0x3F stops the core 2 cycles after its fetch starts. `halted` then stays high, `imem_addr` holds at the halt address + 1 word, and no memory strobe is raised until reset.
- R10: Any other opcode writes nothing and takes 2 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr | output | IAW | Word address of the instruction being fetched |
| imem_rdata | input | 32 | Instruction word, combinational from `imem_addr` |
| dmem_addr | output | DAW | Word address of the data access |
| dmem_rdata | input | 32 | Read data, combinational from `dmem_addr` |
| dmem_wdata | output | 32 | Store data |
| dmem_re | output | 1 | Load strobe, high during the memory step of a load |
| dmem_we | output | 1 | Store strobe; memory writes on the rising edge while high |
| halted | output | 1 | High once a halt instruction has been decoded |

## Verification
Results arrive at fixed times. A program that releases reset before edge 1 raises `halted` right after edge S+2, where S is 4 per ALU op or store, 5 per load and 2 per branch or unknown opcode. The bench adds these costs up from the program text and compares the edge count at which `halted` is first seen at a falling edge. Register results are stored to data memory, and the bench reads them only after the halt, so every value is checked after its write edge. Post-halt behaviour is sampled at falling edges over several extra cycles.

// File: rtl/mc5_pkg.sv
package mc5_pkg;

    localparam int XLEN     = 32;
    localparam int REG_BITS = 5;

    localparam logic [5:0] OPC_RR   = 6'h00;
    localparam logic [5:0] OPC_BEQ  = 6'h04;
    localparam logic [5:0] OPC_ADDI = 6'h08;
    localparam logic [5:0] OPC_SLTI = 6'h0A;
    localparam logic [5:0] OPC_ANDI = 6'h0C;
    localparam logic [5:0] OPC_ORI  = 6'h0D;
    localparam logic [5:0] OPC_XORI = 6'h0E;
    localparam logic [5:0] OPC_LW   = 6'h23;
    localparam logic [5:0] OPC_SW   = 6'h2B;
    localparam logic [5:0] OPC_HALT = 6'h3F;

    typedef enum logic [2:0] {
        ST_FETCH, ST_DECODE, ST_EXEC, ST_MEM, ST_WB, ST_HALT
    } step_e;

    typedef enum logic [2:0] {
        ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_XOR, ALU_SLT
    } alu_op_e;

    typedef enum logic [2:0] {
        K_RR, K_RI, K_LD, K_ST, K_BR, K_HALT, K_NOP
    } kind_e;

    typedef struct packed {
        kind_e                kind;
        alu_op_e              op;
        logic [REG_BITS-1:0]  src1;
        logic [REG_BITS-1:0]  src2;
        logic [REG_BITS-1:0]  dst;
        logic [XLEN-1:0]      simm;
    } dec_t;

    function automatic logic [XLEN-1:0] sext16(input logic [15:0] v);
        return {{(XLEN-16){v[15]}}, v};
    endfunction

    function automatic alu_op_e rr_func(input logic [2:0] f);
        case (f)
            3'd1:    return ALU_SUB;
            3'd2:    return ALU_AND;
            3'd3:    return ALU_OR;
            3'd4:    return ALU_XOR;
            3'd5:    return ALU_SLT;
            default: return ALU_ADD;
        endcase
    endfunction

    function automatic dec_t decode(input logic [XLEN-1:0] ir);
        dec_t d;
        d.src1 = ir[25:21];
        d.src2 = ir[20:16];
        d.dst  = ir[20:16];
        d.simm = sext16(ir[15:0]);
        d.op   = ALU_ADD;
        d.kind = K_NOP;
        case (ir[31:26])
            OPC_RR: begin
                d.kind = K_RR;
                d.dst  = ir[15:11];
                d.op   = rr_func(ir[2:0]);
            end
            OPC_ADDI: d.kind = K_RI;
            OPC_SLTI: begin d.kind = K_RI; d.op = ALU_SLT; end
            OPC_ANDI: begin d.kind = K_RI; d.op = ALU_AND; end
            OPC_ORI:  begin d.kind = K_RI; d.op = ALU_OR;  end
            OPC_XORI: begin d.kind = K_RI; d.op = ALU_XOR; end
            OPC_LW:   d.kind = K_LD;
            OPC_SW:   d.kind = K_ST;
            OPC_BEQ:  d.kind = K_BR;
            OPC_HALT: d.kind = K_HALT;
            default:  d.kind = K_NOP;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/mc5_regs.sv
module mc5_regs #(
    parameter int NREG = 32,
    parameter int W    = 32,
    localparam int AW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic [AW-1:0] raddr1,
    input  logic [AW-1:0] raddr2,
    output logic [W-1:0]  rdata1,
    output logic [W-1:0]  rdata2,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata
);
    logic [W-1:0] cells [NREG];

    always_ff @(posedge clk) begin
        if (we && (waddr != '0))
            cells[waddr] <= wdata;
    end

    assign rdata1 = (raddr1 == '0) ? '0 : cells[raddr1];
    assign rdata2 = (raddr2 == '0) ? '0 : cells[raddr2];
endmodule

// File: rtl/mc5_alu.sv
module mc5_alu
    import mc5_pkg::*;
#(
    parameter int W = 32
) (
    input  alu_op_e       op,
    input  logic [W-1:0]  a,
    input  logic [W-1:0]  b,
    output logic [W-1:0]  y
);
    always_comb begin
        case (op)
            ALU_SUB: y = a - b;
            ALU_AND: y = a & b;
            ALU_OR:  y = a | b;
            ALU_XOR: y = a ^ b;
            ALU_SLT: y = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
            default: y = a + b;
        endcase
    end
endmodule

// File: rtl/mc5_seq.sv
module mc5_seq
    import mc5_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  kind_e kind,
    output step_e step
);
    step_e nxt;

    always_comb begin
        nxt = step;
        case (step)
            ST_FETCH:  nxt = ST_DECODE;
            ST_DECODE: begin
                case (kind)
                    K_BR, K_NOP: nxt = ST_FETCH;
                    K_HALT:      nxt = ST_HALT;
                    default:     nxt = ST_EXEC;
                endcase
            end
            ST_EXEC:   nxt = (kind == K_LD || kind == K_ST) ? ST_MEM : ST_WB;
            ST_MEM:    nxt = (kind == K_LD) ? ST_WB : ST_FETCH;
            ST_WB:     nxt = ST_FETCH;
            ST_HALT:   nxt = ST_HALT;
            default:   nxt = ST_FETCH;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) step <= ST_FETCH;
        else     step <= nxt;
    end

    AST_BRANCH_SHORT: assert property (@(posedge clk) disable iff (rst)
        (step == ST_DECODE && kind == K_BR) |=> step == ST_FETCH) else $error("branch overran"); // R6
    AST_WB_RETURNS: assert property (@(posedge clk) disable iff (rst)
        (step == ST_WB) |=> step == ST_FETCH) else $error("write-back not last"); // R7
endmodule

// File: rtl/mc5_core.sv
module mc5_core
    import mc5_pkg::*;
#(
    parameter int IAW  = 10,
    parameter int DAW  = 10,
    parameter int NREG = 32,
    localparam int PCW = IAW + 2
) (
    input  logic              clk,
    input  logic              rst,
    output logic [IAW-1:0]    imem_addr,
    input  logic [XLEN-1:0]   imem_rdata,
    output logic [DAW-1:0]    dmem_addr,
    input  logic [XLEN-1:0]   dmem_rdata,
    output logic [XLEN-1:0]   dmem_wdata,
    output logic              dmem_re,
    output logic              dmem_we,
    output logic              halted
);
    step_e           step;
    logic [PCW-1:0]  pc;
    logic [XLEN-1:0] ir, opa_q, opb_q, res_q, mdr_q;
    dec_t            dec;
    logic [XLEN-1:0] rd1, rd2, alu_b, alu_y;
    logic            operands_eq;
    logic [PCW-1:0]  br_target;
    logic            rf_we;

    assign dec = decode(ir);

    mc5_seq i_seq (
        .clk  (clk),
        .rst  (rst),
        .kind (dec.kind),
        .step (step)
    );

    mc5_regs #(.NREG(NREG), .W(XLEN)) i_regs (
        .clk    (clk),
        .raddr1 (dec.src1),
        .raddr2 (dec.src2),
        .rdata1 (rd1),
        .rdata2 (rd2),
        .we     (rf_we),
        .waddr  (dec.dst),
        .wdata  ((dec.kind == K_LD) ? mdr_q : res_q)
    );

    // decode-step work: equality and target beside the register read
    assign operands_eq = (rd1 == rd2);
    assign br_target   = pc + PCW'(dec.simm << 2);

    assign alu_b = (dec.kind == K_RR) ? opb_q : dec.simm;

    mc5_alu #(.W(XLEN)) i_alu (
        .op (dec.op),
        .a  (opa_q),
        .b  (alu_b),
        .y  (alu_y)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pc <= '0;
        end else begin
            case (step)
                ST_FETCH: begin
                    ir <= imem_rdata;
                    pc <= pc + PCW'(4);
                end
                ST_DECODE: begin
                    opa_q <= rd1;
                    opb_q <= rd2;
                    if (dec.kind == K_BR && operands_eq)
                        pc <= br_target;
                end
                ST_EXEC: res_q <= alu_y;
                ST_MEM:  mdr_q <= dmem_rdata;
                default: ;
            endcase
        end
    end

    assign rf_we      = (step == ST_WB);
    assign imem_addr  = pc[PCW-1:2];
    assign dmem_addr  = res_q[DAW+1:2];
    assign dmem_wdata = opb_q;
    assign dmem_re    = (step == ST_MEM) && (dec.kind == K_LD);
    assign dmem_we    = (step == ST_MEM) && (dec.kind == K_ST);
    assign halted     = (step == ST_HALT);

    AST_PC_STEP: assert property (@(posedge clk) disable iff (rst)
        (step == ST_FETCH) |=> pc == $past(pc) + PCW'(4)) else $error("pc not advanced"); // R2
    AST_STORE_ENDS: assert property (@(posedge clk) disable iff (rst)
        dmem_we |=> (step == ST_FETCH)) else $error("store did not end"); // R7
    AST_LOAD_TO_WB: assert property (@(posedge clk) disable iff (rst)
        dmem_re |=> (step == ST_WB)) else $error("load skipped write-back"); // R7
    AST_HALT_HOLD: assert property (@(posedge clk) disable iff (rst)
        halted |=> halted && $stable(imem_addr)) else $error("halt released"); // R9
    AST_HALT_QUIET: assert property (@(posedge clk) disable iff (rst)
        halted |-> !dmem_re && !dmem_we) else $error("strobe while halted"); // R9
    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(dmem_re && dmem_we)) else $error("both strobes"); // R5
endmodule

// File: tb/test_mc5_core.sv
module test_mc5_core;
    localparam int IAW = 10;
    localparam int DAW = 10;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [IAW-1:0]  imem_addr;
    logic [31:0]     imem_rdata;
    logic [DAW-1:0]  dmem_addr;
    logic [31:0]     dmem_rdata;
    logic [31:0]     dmem_wdata;
    logic            dmem_re, dmem_we, halted;

    logic [31:0] imem [1 << IAW];
    logic [31:0] dmem [1 << DAW];

    int n_cmp = 0;
    int n_bad = 0;
    int total_cycles = 0;

    always #10 clk = ~clk;

    mc5_core #(.IAW(IAW), .DAW(DAW)) i_mc5_core (
        .clk(clk), .rst(rst),
        .imem_addr(imem_addr), .imem_rdata(imem_rdata),
        .dmem_addr(dmem_addr), .dmem_rdata(dmem_rdata), .dmem_wdata(dmem_wdata),
        .dmem_re(dmem_re), .dmem_we(dmem_we), .halted(halted)
    );

    assign imem_rdata = imem[imem_addr];
    assign dmem_rdata = dmem[dmem_addr];

    always @(posedge clk) if (dmem_we) dmem[dmem_addr] <= dmem_wdata;

    always @(posedge clk) begin
        total_cycles <= total_cycles + 1;
        if (total_cycles > 190000) begin
            n_bad++;
            $display("FAIL watchdog: actual %0d cycles, expected under 190000", total_cycles);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] e_rr(input int f, input int rd, input int rs, input int rt);
        return {6'h00, 5'(rs), 5'(rt), 5'(rd), 8'd0, 3'(f)};
    endfunction
    function automatic logic [31:0] e_i(input logic [5:0] op, input int rt, input int rs, input logic [15:0] imm);
        return {op, 5'(rs), 5'(rt), imm};
    endfunction
    function automatic logic [31:0] sx(input logic [15:0] v);
        return {{16{v[15]}}, v};
    endfunction

    task automatic clear_mem();
        for (int i = 0; i < (1 << IAW); i++) imem[i] = 32'hFC00_0000;
        for (int i = 0; i < (1 << DAW); i++) dmem[i] = 32'hDEAD_BEEF;
    endtask

    // runs from reset; returns edges until halted seen
    task automatic run(output int cyc);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        cyc = 0;
        while (!halted && cyc < 3000) begin
            @(posedge clk);
            cyc++;
            @(negedge clk);
        end
    endtask

    logic [15:0] vals [6] = '{16'h0000, 16'h0001, 16'hFFFF, 16'h7FFF, 16'h8000, 16'h00F3};

    initial begin
        int cyc;
        logic [31:0] a, b, exp;
        logic [IAW-1:0] held;

        // R1 reset state
        clear_mem();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 imem_addr", 32'(imem_addr), 32'd0);
        check("R1 halted", 32'(halted), 32'd0);
        check("R1 strobes", {30'd0, dmem_re, dmem_we}, 32'd0);

        // R3 R4 sweep over operand pairs
        for (int i = 0; i < 6; i++) begin
            for (int j = 0; j < 6; j++) begin
                clear_mem();
                imem[0] = e_i(6'h08, 1, 0, vals[i]);
                imem[1] = e_i(6'h08, 2, 0, vals[j]);
                for (int f = 0; f < 6; f++) imem[2 + f] = e_rr(f, 3 + f, 1, 2);
                imem[8]  = e_i(6'h08, 9,  1, vals[j]);
                imem[9]  = e_i(6'h0A, 10, 1, vals[j]);
                imem[10] = e_i(6'h0C, 11, 1, vals[j]);
                imem[11] = e_i(6'h0D, 12, 1, vals[j]);
                imem[12] = e_i(6'h0E, 13, 1, vals[j]);
                for (int k = 0; k < 11; k++) imem[13 + k] = e_i(6'h2B, 3 + k, 0, 16'(4 * k));
                imem[24] = 32'hFC00_0000;
                run(cyc);
                check("R7 alu/store cycle count", 32'(cyc), 32'(24 * 4 + 2));
                a = sx(vals[i]);
                b = sx(vals[j]);
                for (int k = 0; k < 11; k++) begin
                    case (k % 5 + (k >= 6 ? 0 : 0))
                        default: exp = 0;
                    endcase
                    case (k)
                        0, 6:  exp = a + b;
                        1:     exp = a - b;
                        2, 8:  exp = a & b;
                        3, 9:  exp = a | b;
                        4, 10: exp = a ^ b;
                        default: exp = {31'd0, $signed(a) < $signed(b)};
                    endcase
                    check(k < 6 ? "R3 register-register op" : "R4 register-immediate op", dmem[k], exp);
                end
            end
        end

        // R5 R8 loads, stores, register 0
        clear_mem();
        imem[0] = e_i(6'h08, 1, 0, 16'h0040);
        imem[1] = e_i(6'h08, 2, 0, 16'hFFFB);
        imem[2] = e_i(6'h2B, 2, 1, 16'hFFF8);
        imem[3] = e_i(6'h23, 3, 1, 16'hFFF8);
        imem[4] = e_i(6'h23, 0, 1, 16'hFFF8);
        imem[5] = e_i(6'h08, 0, 0, 16'h0009);
        imem[6] = e_i(6'h2B, 3, 1, 16'h0004);
        imem[7] = e_i(6'h2B, 0, 1, 16'h0008);
        imem[8] = 32'hFC00_0000;
        run(cyc);
        check("R5 store at negative offset", dmem[14], 32'hFFFF_FFFB);
        check("R5 load round trip", dmem[17], 32'hFFFF_FFFB);
        check("R8 register 0 stays zero", dmem[18], 32'd0);
        check("R7 load cycle count", 32'(cyc), 32'(4 * 6 + 5 * 2 + 2));

        // R7 pure per-type costs
        clear_mem();
        for (int k = 0; k < 3; k++) imem[k] = e_i(6'h23, 4, 0, 16'd0);
        run(cyc);
        check("R7 three loads", 32'(cyc), 32'd17);

        // R6 branch loop, backward and forward targets
        clear_mem();
        imem[0] = e_i(6'h08, 1, 0, 16'd5);
        imem[1] = e_i(6'h08, 2, 0, 16'd0);
        imem[2] = e_i(6'h08, 2, 2, 16'd1);
        imem[3] = e_i(6'h04, 1, 2, 16'd1);
        imem[4] = e_i(6'h04, 0, 0, 16'hFFFD);
        imem[5] = e_i(6'h2B, 2, 0, 16'd0);
        imem[6] = 32'hFC00_0000;
        run(cyc);
        check("R6 loop result", dmem[0], 32'd5);
        check("R6 loop cycle count", 32'(cyc), 32'd52);
        check("R2 halt fetch address", 32'(imem_addr), 32'd7);

        // R6 taken forward skip
        clear_mem();
        imem[0] = e_i(6'h08, 6, 0, 16'd11);
        imem[1] = e_i(6'h04, 0, 0, 16'd1);
        imem[2] = e_i(6'h08, 6, 0, 16'd99);
        imem[3] = e_i(6'h2B, 6, 0, 16'd4);
        imem[4] = 32'hFC00_0000;
        run(cyc);
        check("R6 skipped instruction", dmem[1], 32'd11);
        check("R6 taken branch cycles", 32'(cyc), 32'd12);

        // R6 not-taken branches
        clear_mem();
        imem[0] = e_i(6'h08, 1, 0, 16'd1);
        for (int k = 1; k < 4; k++) imem[k] = e_i(6'h04, 0, 1, 16'd100);
        imem[4] = 32'hFC00_0000;
        run(cyc);
        check("R6 not-taken cycles", 32'(cyc), 32'd12);
        check("R2 sequential fetch after not-taken", 32'(imem_addr), 32'd5);

        // R10 unknown opcode
        clear_mem();
        imem[0] = e_i(6'h08, 1, 0, 16'd7);
        imem[1] = e_i(6'h3A, 1, 0, 16'h0800);
        imem[2] = e_i(6'h2B, 1, 0, 16'd0);
        imem[3] = 32'hFC00_0000;
        run(cyc);
        check("R10 unknown opcode writes nothing", dmem[0], 32'd7);
        check("R10 unknown opcode cycles", 32'(cyc), 32'd12);

        // R9 halt holds
        held = imem_addr;
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            check("R9 halted stays", {29'd0, halted, dmem_re, dmem_we}, 32'd4);
            check("R9 fetch address frozen", 32'(imem_addr), 32'(held));
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule